// File: doc/BRIEF.md
# Text Overlay Character Fetch Sequencer

This block produces the stream of character cells for a text overlay of 12 rows by 24 columns. At the start of each field it walks the rows in order. For every row it takes an 11-bit start address from that row's base register, then reads 24 consecutive entries of a 1536-entry line table. An entry either carries a 7-bit character code itself, or it redirects the cell to a shared 176-word variable-character RAM. That RAM is not addressed by the entry. Its locations are handed out in display order, one per redirected cell, starting from location 0 in every field.

Each cell leaves the block on a valid/ready stream with its code, its blink attribute, and its row and column position. A downstream glyph renderer consumes the stream. A cell is transferred only in a cycle where `cell_valid` and `cell_ready` are both high. While `cell_ready` is low, the cell on the outputs is held unchanged and the sequencer does not advance, so no cell is lost or repeated. `cell_valid` may rise without waiting for `cell_ready`.

The row base registers and the variable RAM are written through plain write ports. The line table is a constant table built at elaboration.

Top module: `text_cell_sequencer`

## Requirements
- R1: After reset `cell_valid` is low, and it stays low until the first `field_start` pulse.
- R2: A `field_start` pulse begins a field. The block then delivers exactly 288 cells in row-major order: `cell_row` runs 0 to 11 and, inside each row, `cell_col` runs 0 to 23. After the last cell `cell_valid` stays low until the next `field_start`.
- R3: The cell at row r, column c reads the line table at address B + c. B is the value last written to row base register r, where `row_widx` = r and r runs 0 to 11. B is any 11-bit value and need not be a multiple of 24.
- R4: A line-table entry whose bit 7 is 0 is direct. The cell's code is bits 6:0 of the entry and its blink bit is 0.
- R5: A line-table entry whose bit 7 is 1 is redirected. The cell takes its data from the variable RAM word at the current RAM pointer: blink is bit 7 and the code is bits 6:0. The pointer is 0 at the start of every field and steps by one after each redirected cell, in display order.
- R6: Once 176 redirected cells have been delivered in a field, every further redirected cell in that field carries code 0 and blink 0.
- R7: The line table holds the following for address a below 1536, with line L = a / 24 and position p = a mod 24. If L >= 32, the entry is 8'h80. If L < 32 and p mod 4 = 3, the entry is 8'h80. Otherwise the entry is {1'b0, (7L + 3p) mod 128}. Any address of 1536 or more reads as 8'h00.
- R8: While `cell_valid` is high and `cell_ready` is low, `cell_valid`, `cell_code`, `cell_blink`, `cell_row` and `cell_col` stay stable.
- R9: `field_start` takes priority over everything else. A cell handshaken in the same cycle as `field_start` counts as delivered. In the next cycle `cell_valid` is low, and the next cell delivered is row 0, column 0 of the new field, read with the RAM pointer back at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_start | input | 1 | One-cycle pulse that restarts the walk at row 0 |
| row_we | input | 1 | Row base register write enable |
| row_widx | input | 4 | Row base register index, 0 to 11 |
| row_wdata | input | 11 | Line-table start address for that row |
| vram_we | input | 1 | Variable RAM write enable |
| vram_waddr | input | 8 | Variable RAM word address, 0 to 175 |
| vram_wdata | input | 8 | Word: bit 7 is blink, bits 6:0 are the code |
| cell_ready | input | 1 | Downstream can accept a cell |
| cell_valid | output | 1 | A cell is presented |
| cell_code | output | 7 | Character code of the cell |
| cell_blink | output | 1 | Blink attribute of the cell |
| cell_row | output | 4 | Row of the cell, 0 to 11 |
| cell_col | output | 5 | Column of the cell, 0 to 23 |

## Verification
Two functions can fall in the same cycle: the field restart and the consumption of a cell. The bench provokes this by taking 30 cells of a field, then raising `field_start` and `cell_ready` together while cell 30 is presented. It judges cell 30 as delivered. It then requires `cell_valid` to be low in the following cycle, and requires the whole next field to match the model from row 0, column 0 with the RAM pointer back at 0.

// File: rtl/osd_seq_pkg.sv
package osd_seq_pkg;

  // Constant line-table contents, computed from the address.
  function automatic logic [7:0] table_entry(int unsigned a, int unsigned cols,
                                             int unsigned lines);
    int unsigned ln;
    int unsigned pos;
    logic [7:0]  e;
    ln  = a / cols;
    pos = a % cols;
    if (ln >= lines / 2)      e = 8'h80;
    else if ((pos % 4) == 3)  e = 8'h80;
    else                      e = {1'b0, 7'((ln * 7 + pos * 3) % 128)};
    return e;
  endfunction

endpackage

// File: rtl/osd_line_table.sv
module osd_line_table #(
  parameter int COLS  = 24,
  parameter int LINES = 64,
  parameter int AW    = 12,
  localparam int DEPTH = COLS * LINES
) (
  input  logic [AW-1:0] addr,
  output logic [7:0]    data
);
  logic [7:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = osd_seq_pkg::table_entry(i, COLS, LINES);
  end

  // Reads past the last line return zero (R7).
  always_comb begin
    if (int'(addr) < DEPTH) data = rom[addr];
    else                    data = 8'h00;
  end
endmodule

// File: rtl/osd_var_ram.sv
module osd_var_ram #(
  parameter int DEPTH = 176,
  parameter int AW    = 8,
  parameter int RW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [RW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && int'(waddr) < DEPTH) mem[waddr] <= wdata;
  end

  always_comb begin
    if (int'(raddr) < DEPTH) rdata = mem[raddr];
    else                     rdata = 8'h00;
  end
endmodule

// File: rtl/osd_row_bases.sv
module osd_row_bases #(
  parameter int ROWS = 12,
  parameter int IW   = 4,
  parameter int DW   = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] base_q [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                base_q[r] <= '0;
      else if (we && widx == IW'(r))             base_q[r] <= wdata;
    end
  end

  always_comb begin
    if (int'(ridx) < ROWS) rdata = base_q[ridx];
    else                   rdata = '0;
  end
endmodule

// File: rtl/osd_seq_ctrl.sv
module osd_seq_ctrl #(
  parameter int COLS       = 24,
  parameter int ROWS       = 12,
  parameter int VRAM_DEPTH = 176,
  parameter int BW         = 11,
  parameter int AW         = 12,
  parameter int VP_W       = 8,
  parameter int RI_W       = 4,
  parameter int CI_W       = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            field_start,
  input  logic            advance,
  input  logic            entry_ram,
  input  logic [BW-1:0]   base_rd,
  output logic [RI_W-1:0] row_sel,
  output logic            active,
  output logic [RI_W-1:0] row,
  output logic [CI_W-1:0] col,
  output logic [AW-1:0]   addr,
  output logic [VP_W-1:0] vptr,
  output logic            vptr_ok
);
  logic            active_q;
  logic [RI_W-1:0] row_q;
  logic [CI_W-1:0] col_q;
  logic [AW-1:0]   addr_q;
  logic [VP_W-1:0] vptr_q;
  logic            last_col;
  logic            last_row;

  assign last_col = (col_q == CI_W'(COLS - 1));
  assign last_row = (row_q == RI_W'(ROWS - 1));
  assign vptr_ok  = (int'(vptr_q) < VRAM_DEPTH);

  // Base register read: row 0 on a restart, otherwise the row after this one.
  always_comb begin
    if (field_start || last_row) row_sel = '0;
    else                         row_sel = row_q + RI_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
      addr_q   <= '0;
      vptr_q   <= '0;
    end else if (field_start) begin
      active_q <= 1'b1;
      row_q    <= '0;
      col_q    <= '0;
      addr_q   <= AW'(base_rd);
      vptr_q   <= '0;
    end else if (advance) begin
      if (entry_ram && vptr_ok) vptr_q <= vptr_q + VP_W'(1);
      if (last_col) begin
        col_q <= '0;
        if (last_row) begin
          active_q <= 1'b0;
        end else begin
          row_q  <= row_q + RI_W'(1);
          addr_q <= AW'(base_rd);
        end
      end else begin
        col_q  <= col_q + CI_W'(1);
        addr_q <= addr_q + AW'(1);
      end
    end
  end

  assign active = active_q;
  assign row    = row_q;
  assign col    = col_q;
  assign addr   = addr_q;
  assign vptr   = vptr_q;

  p_ptr_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(vptr_q) <= VRAM_DEPTH);

  p_pos_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(col_q) < COLS) && (int'(row_q) < ROWS));

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> active_q && vptr_q == '0 && row_q == '0 && col_q == '0);

  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !field_start && !entry_ram) |=> $stable(vptr_q));
endmodule

// File: rtl/osd_cell_out.sv
module osd_cell_out #(
  parameter int PW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          load,
  input  logic [PW-1:0] load_data,
  output logic          can_load,
  input  logic          ready,
  output logic          valid,
  output logic [PW-1:0] data
);
  logic          valid_q;
  logic [PW-1:0] data_q;

  assign can_load = !valid_q || ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (flush) begin
      valid_q <= 1'b0;
    end else if (load) begin
      valid_q <= 1'b1;
      data_q  <= load_data;
    end else if (ready) begin
      valid_q <= 1'b0;
    end
  end

  assign valid = valid_q;
  assign data  = data_q;

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready && !flush) |=> valid_q && $stable(data_q));

  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !valid_q);
endmodule

// File: rtl/text_cell_sequencer.sv
module text_cell_sequencer #(
  parameter int COLS       = 24,
  parameter int ROWS       = 12,
  parameter int LINES      = 64,
  parameter int VRAM_DEPTH = 176,
  parameter int CODE_W     = 7,
  localparam int TBL_DEPTH = COLS * LINES,
  localparam int BW        = $clog2(TBL_DEPTH),
  localparam int AW        = BW + 1,
  localparam int VA_W      = $clog2(VRAM_DEPTH),
  localparam int VP_W      = $clog2(VRAM_DEPTH + 1),
  localparam int RI_W      = $clog2(ROWS),
  localparam int CI_W      = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_start,
  input  logic              row_we,
  input  logic [RI_W-1:0]   row_widx,
  input  logic [BW-1:0]     row_wdata,
  input  logic              vram_we,
  input  logic [VA_W-1:0]   vram_waddr,
  input  logic [7:0]        vram_wdata,
  input  logic              cell_ready,
  output logic              cell_valid,
  output logic [CODE_W-1:0] cell_code,
  output logic              cell_blink,
  output logic [RI_W-1:0]   cell_row,
  output logic [CI_W-1:0]   cell_col
);
  localparam int PW = CODE_W + 1 + RI_W + CI_W;

  logic [RI_W-1:0]   row_sel;
  logic [BW-1:0]     base_rd;
  logic              active;
  logic [RI_W-1:0]   row;
  logic [CI_W-1:0]   col;
  logic [AW-1:0]     addr;
  logic [VP_W-1:0]   vptr;
  logic              vptr_ok;
  logic [7:0]        tbl_data;
  logic [7:0]        vram_rd;
  logic              can_load;
  logic              fire;
  logic [CODE_W-1:0] next_code;
  logic              next_blink;
  logic [PW-1:0]     out_data;

  osd_row_bases #(.ROWS(ROWS), .IW(RI_W), .DW(BW)) u_bases (
    .clk(clk), .rst_n(rst_n), .we(row_we), .widx(row_widx), .wdata(row_wdata),
    .ridx(row_sel), .rdata(base_rd)
  );

  osd_seq_ctrl #(
    .COLS(COLS), .ROWS(ROWS), .VRAM_DEPTH(VRAM_DEPTH), .BW(BW), .AW(AW),
    .VP_W(VP_W), .RI_W(RI_W), .CI_W(CI_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .field_start(field_start), .advance(fire),
    .entry_ram(tbl_data[7]), .base_rd(base_rd), .row_sel(row_sel),
    .active(active), .row(row), .col(col), .addr(addr), .vptr(vptr),
    .vptr_ok(vptr_ok)
  );

  osd_line_table #(.COLS(COLS), .LINES(LINES), .AW(AW)) u_table (
    .addr(addr), .data(tbl_data)
  );

  osd_var_ram #(.DEPTH(VRAM_DEPTH), .AW(VA_W), .RW(VP_W)) u_vram (
    .clk(clk), .we(vram_we), .waddr(vram_waddr), .wdata(vram_wdata),
    .raddr(vptr), .rdata(vram_rd)
  );

  // A restart in this cycle wins over fetching the next cell.
  assign fire = active && can_load && !field_start;

  always_comb begin
    if (!tbl_data[7]) begin
      next_code  = tbl_data[CODE_W-1:0];
      next_blink = 1'b0;
    end else if (vptr_ok) begin
      next_code  = vram_rd[CODE_W-1:0];
      next_blink = vram_rd[7];
    end else begin
      next_code  = '0;
      next_blink = 1'b0;
    end
  end

  osd_cell_out #(.PW(PW)) u_out (
    .clk(clk), .rst_n(rst_n), .flush(field_start), .load(fire),
    .load_data({next_code, next_blink, row, col}), .can_load(can_load),
    .ready(cell_ready), .valid(cell_valid), .data(out_data)
  );

  assign {cell_code, cell_blink, cell_row, cell_col} = out_data;

  p_direct_noblink_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !tbl_data[7]) |=> cell_valid && !cell_blink);

  p_sat_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && tbl_data[7] && !vptr_ok) |=> cell_code == '0 && !cell_blink);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !field_start && cell_valid && cell_ready) |=> !cell_valid);
endmodule

// File: tb/test_text_cell_sequencer.sv
module test_text_cell_sequencer;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        field_start = 0;
  logic        row_we = 0;
  logic [3:0]  row_widx = 0;
  logic [10:0] row_wdata = 0;
  logic        vram_we = 0;
  logic [7:0]  vram_waddr = 0;
  logic [7:0]  vram_wdata = 0;
  logic        cell_ready = 0;
  logic        cell_valid;
  logic [6:0]  cell_code;
  logic        cell_blink;
  logic [3:0]  cell_row;
  logic [4:0]  cell_col;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int   bases [12];
  logic [7:0] vmodel [176];
  logic [6:0] exp_code [288];
  logic       exp_blink [288];

  always #4 clk = ~clk;

  text_cell_sequencer i_text_cell_sequencer (
    .clk(clk), .rst_n(rst_n), .field_start(field_start), .row_we(row_we),
    .row_widx(row_widx), .row_wdata(row_wdata), .vram_we(vram_we),
    .vram_waddr(vram_waddr), .vram_wdata(vram_wdata), .cell_ready(cell_ready),
    .cell_valid(cell_valid), .cell_code(cell_code), .cell_blink(cell_blink),
    .cell_row(cell_row), .cell_col(cell_col)
  );

  task automatic summary_and_end();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      summary_and_end();
    end
  end

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Table contents as stated in R7.
  function automatic logic [7:0] tbl_model(int a);
    int ln, p;
    if (a >= 1536) return 8'h00;
    ln = a / 24; p = a % 24;
    if (ln >= 32) return 8'h80;
    if (p % 4 == 3) return 8'h80;
    return {1'b0, 7'((ln * 7 + p * 3) % 128)};
  endfunction

  // Expected cell stream per R3, R4, R5 and R6.
  task automatic build_expected();
    int ptr = 0;
    for (int r = 0; r < 12; r++) begin
      for (int c = 0; c < 24; c++) begin
        logic [7:0] e;
        int k;
        k = r * 24 + c;
        e = tbl_model(bases[r] + c);
        if (!e[7]) begin
          exp_code[k] = e[6:0]; exp_blink[k] = 1'b0;
        end else if (ptr < 176) begin
          exp_code[k] = vmodel[ptr][6:0]; exp_blink[k] = vmodel[ptr][7];
          ptr++;
        end else begin
          exp_code[k] = 7'd0; exp_blink[k] = 1'b0;
        end
      end
    end
  endtask

  task automatic write_rows();
    for (int r = 0; r < 12; r++) begin
      @(negedge clk);
      row_we = 1; row_widx = 4'(r); row_wdata = 11'(bases[r]);
    end
    @(negedge clk); row_we = 0;
  endtask

  task automatic write_vram(int seed);
    for (int p = 0; p < 176; p++) begin
      vmodel[p] = {1'(((p >> 1) ^ seed) & 1), 7'((p * 11 + seed) % 128)};
      @(negedge clk);
      vram_we = 1; vram_waddr = 8'(p); vram_wdata = vmodel[p];
    end
    @(negedge clk); vram_we = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); field_start = 1;
    @(negedge clk); field_start = 0;
  endtask

  // Take cells first..last, comparing each; mode 1 stalls one cycle in three.
  task automatic consume(int first, int last, int mode, string req);
    int i = first;
    int cyc = 0;
    bit stalled = 0;
    logic [17:0] held = '0;
    while (i <= last && cyc < 5000) begin
      bit rdy;
      @(negedge clk);
      if (stalled) begin
        check(cell_valid && {cell_code, cell_blink, cell_row, cell_col} == held,
              "R8", "payload held under stall",
              int'({cell_code, cell_blink, cell_row, cell_col}), int'(held));
      end
      rdy = (mode == 0) || (cyc % 3 != 1);
      cell_ready = rdy;
      if (cell_valid && rdy) begin
        check(int'(cell_row) == i / 24 && int'(cell_col) == i % 24, "R2",
              "cell position", int'(cell_row) * 24 + int'(cell_col), i);
        check(cell_code == exp_code[i], req, $sformatf("code of cell %0d", i),
              int'(cell_code), int'(exp_code[i]));
        check(cell_blink == exp_blink[i], req, $sformatf("blink of cell %0d", i),
              int'(cell_blink), int'(exp_blink[i]));
        i++;
      end
      stalled = cell_valid && !rdy;
      held = {cell_code, cell_blink, cell_row, cell_col};
      cyc++;
    end
    check(i > last, req, "stream delivered all cells", i, last + 1);
    @(negedge clk); cell_ready = 0;
  endtask

  task automatic t_reset_r1();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check(cell_valid == 0, "R1", "valid after reset", int'(cell_valid), 0);
    cell_ready = 1;
    repeat (6) @(negedge clk);
    check(cell_valid == 0, "R1", "valid without field start", int'(cell_valid), 0);
    cell_ready = 0;
  endtask

  task automatic t_basic_field_r3();
    for (int r = 0; r < 12; r++) bases[r] = (r * 5 + 3) * 24;
    bases[3] = 7;
    bases[7] = 100;
    write_rows();
    write_vram(5);
    build_expected();
    pulse_start();
    consume(0, 287, 0, "R3/R4/R5/R7");
    cell_ready = 1;
    repeat (5) @(negedge clk);
    check(cell_valid == 0, "R2", "valid low after 288 cells", int'(cell_valid), 0);
    cell_ready = 0;
  endtask

  task automatic t_backpressure_r8();
    build_expected();
    pulse_start();
    consume(0, 287, 1, "R8");
  endtask

  task automatic t_saturation_r6();
    for (int r = 0; r < 12; r++) bases[r] = 40 * 24;
    write_rows();
    write_vram(9);
    build_expected();
    pulse_start();
    consume(0, 287, 0, "R6");
  endtask

  task automatic t_out_of_range_r7();
    for (int r = 0; r < 12; r++) bases[r] = r * 24;
    bases[0] = 1520;
    bases[1] = 2047;
    write_rows();
    build_expected();
    pulse_start();
    consume(0, 287, 0, "R7");
  endtask

  task automatic t_restart_collision_r9();
    for (int r = 0; r < 12; r++) bases[r] = (11 - r) * 48;
    write_rows();
    write_vram(3);
    build_expected();
    pulse_start();
    consume(0, 29, 0, "R9");
    check(cell_valid == 1, "R9", "cell 30 presented", int'(cell_valid), 1);
    check(cell_code == exp_code[30] && int'(cell_col) == 6, "R9",
          "cell 30 taken in restart cycle", int'(cell_code), int'(exp_code[30]));
    cell_ready = 1; field_start = 1;
    @(negedge clk);
    cell_ready = 0; field_start = 0;
    check(cell_valid == 0, "R9", "valid low after restart", int'(cell_valid), 0);
    consume(0, 287, 0, "R9");
  endtask

  initial begin
    t_reset_r1();
    t_basic_field_r3();
    t_backpressure_r8();
    t_saturation_r6();
    t_out_of_range_r7();
    t_restart_collision_r9();
    repeat (4) @(negedge clk);
    summary_and_end();
  end
endmodule